// File: doc/BRIEF.md
# Tagged Receive Queue with Wildcard Matching

This block sits on the receive side of a node in a message-passing machine. Arriving message headers (source node, message type, length and a buffer handle) are written into a small ordered store. Software-side receive requests name a source node and a message type. The block answers each request with the oldest stored header whose source and type both fit the request, and removes that header. Either request field may be given as -1 to accept any value, and both may be -1 together.

Message types are 16-bit signed values. A type below -1 marks a system message. Such headers are never stored for user requests. Instead they are passed straight to a separate system output one cycle after arrival. A request that names a type below -1 therefore never finds anything. The store holds a fixed number of headers, 16 by default. It reports when it is full and ignores user headers offered while full. Only headers are held here; payload buffers live elsewhere and are referenced through the handle.

The response always follows the request by exactly one cycle and carries either the matched header or a not-found flag. A miss leaves the store untouched. A hit closes the gap left by the removed header without changing the relative order of the headers that remain.

Top module: `rx_tag_queue`

## Requirements
- R1: After reset the store is empty, `queue_full_o` is 0, and `rsp_valid_o` and `sys_valid_o` are 0.
- R2: A request with `req_valid_i` high yields `rsp_valid_o` high in the next cycle and only then. On a hit, `rsp_found_o` is 1 and the source, type, length and handle outputs carry the oldest stored header whose source equals `req_src_i` and whose type equals `req_type_i`.
- R3: A request source of -1 (all ones in the 11-bit signed field) accepts every source. The oldest header with a matching type is returned.
- R4: A request type of -1 accepts every stored type. Source -1 together with type -1 returns the oldest stored header.
- R5: A header whose type is below -1 is not stored. It appears on the `sys_*` outputs with `sys_valid_o` high in the next cycle, whether or not the store is full. A request with a type below -1 always answers not-found, and no user response ever carries a type below -1.
- R6: When no stored header matches, the response in the next cycle has `rsp_found_o` 0 and all header fields 0, and the store contents and order are left unchanged.
- R7: A matched header is removed. All remaining headers keep their arrival order for later requests.
- R8: With the default depth of 16 headers stored, `queue_full_o` is 1 and a user header offered on the enqueue port is discarded.
- R9: When a request and an enqueue occur in the same cycle, the request searches only the headers stored before that cycle. The new header is placed after all surviving headers. The full test uses the occupancy at the start of the cycle.
- R10: The length field is 17 bits wide and carries values up to 65536 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enq_valid_i | input | 1 | Arriving header is present this cycle |
| enq_src_i | input | 10 | Source node of the arriving header |
| enq_type_i | input | 16 | Signed message type of the arriving header |
| enq_len_i | input | 17 | Message length in bytes |
| enq_hnd_i | input | 8 | Payload buffer handle |
| queue_full_o | output | 1 | Store holds its maximum number of headers |
| req_valid_i | input | 1 | Receive request is present this cycle |
| req_src_i | input | 11 | Signed requested source, -1 accepts any |
| req_type_i | input | 16 | Signed requested type, -1 accepts any |
| rsp_valid_o | output | 1 | Response to the request of the previous cycle |
| rsp_found_o | output | 1 | A matching header was found and removed |
| rsp_src_o | output | 10 | Source of the returned header |
| rsp_type_o | output | 16 | Type of the returned header |
| rsp_len_o | output | 17 | Length of the returned header |
| rsp_hnd_o | output | 8 | Handle of the returned header |
| sys_valid_o | output | 1 | A system header arrived in the previous cycle |
| sys_src_o | output | 10 | Source of the system header |
| sys_type_o | output | 16 | Type of the system header |
| sys_len_o | output | 17 | Length of the system header |
| sys_hnd_o | output | 8 | Handle of the system header |

## Verification
The bench aims at the ordering hazards. It stores several headers with the same source and type and checks that they come back oldest first. It also removes from the middle of the store, which a faulty compaction would answer by duplicating or skipping a neighbour. It drives a request and an enqueue in the same cycle on an empty and on a full store. A design that searched the new header, or that tested fullness after removal, would answer found or keep the extra header. It sends system types and wildcard requests, so a design that stored system headers or treated -1 as a literal would return them or miss. A long random phase compares every output against a behavioural queue model on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned NODE_W    = 10;
  localparam int unsigned TYPE_W    = 16;
  localparam int unsigned LEN_W     = 17;
  localparam int unsigned HND_W     = 8;
  localparam int unsigned DEPTH_DEF = 16;

  typedef struct packed {
    logic        [NODE_W-1:0] src;
    logic signed [TYPE_W-1:0] typ;
    logic        [LEN_W-1:0]  len;
    logic        [HND_W-1:0]  hnd;
  } hdr_t;

  localparam logic signed [TYPE_W-1:0] TYPE_ANY = '1;
  localparam logic signed [NODE_W:0]   SRC_ANY  = '1;
endpackage

// File: rtl/rxq_match.sv
module rxq_match #(
  parameter int unsigned DEPTH = 16
) (
  input  rxq_pkg::hdr_t                     ent_i [DEPTH],
  input  logic [DEPTH-1:0]                  vld_i,
  input  logic signed [rxq_pkg::NODE_W:0]   req_src_i,
  input  logic signed [rxq_pkg::TYPE_W-1:0] req_type_i,
  output logic [DEPTH-1:0]                  hit_o
);
  import rxq_pkg::*;

  logic src_wild, type_wild, type_sys;
  assign src_wild  = (req_src_i == SRC_ANY);
  assign type_wild = (req_type_i == TYPE_ANY);
  assign type_sys  = (req_type_i < TYPE_ANY);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic src_ok, type_ok;
    assign src_ok  = src_wild  || (req_src_i == $signed({1'b0, ent_i[g].src}));
    assign type_ok = type_wild || (req_type_i == ent_i[g].typ);
    assign hit_o[g] = vld_i[g] && src_ok && type_ok && !type_sys;
  end
endmodule

// File: rtl/rxq_pick.sv
module rxq_pick #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rm_en_i,
  input  logic [IDX_W-1:0]  rm_idx_i,
  input  logic              ins_en_i,
  input  rxq_pkg::hdr_t     ins_ent_i,
  output rxq_pkg::hdr_t     ent_o [DEPTH],
  output logic [DEPTH-1:0]  vld_o,
  output logic [CNT_W-1:0]  count_o
);
  rxq_pkg::hdr_t    ent_q [DEPTH];
  rxq_pkg::hdr_t    ent_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_n;
  logic             upd;

  assign upd = rm_en_i || ins_en_i;

  always_comb begin
    ent_n   = ent_q;
    cnt_mid = cnt_q;
    if (rm_en_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(rm_idx_i)) ent_n[i] = ent_q[i+1];
      end
      cnt_mid = cnt_q - 1'b1;
    end
    if (ins_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == cnt_mid) ent_n[i] = ins_ent_i;
      end
    end
    cnt_n = cnt_mid + CNT_W'(ins_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (upd) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk_i) begin
    if (upd) ent_q <= ent_n;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_vld
    assign vld_o[g] = (CNT_W'(g) < cnt_q);
  end

  assign ent_o   = ent_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/rx_tag_queue.sv
module rx_tag_queue #(
  parameter int unsigned DEPTH = rxq_pkg::DEPTH_DEF,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              enq_valid_i,
  input  logic [rxq_pkg::NODE_W-1:0]        enq_src_i,
  input  logic signed [rxq_pkg::TYPE_W-1:0] enq_type_i,
  input  logic [rxq_pkg::LEN_W-1:0]         enq_len_i,
  input  logic [rxq_pkg::HND_W-1:0]         enq_hnd_i,
  output logic                              queue_full_o,
  input  logic                              req_valid_i,
  input  logic signed [rxq_pkg::NODE_W:0]   req_src_i,
  input  logic signed [rxq_pkg::TYPE_W-1:0] req_type_i,
  output logic                              rsp_valid_o,
  output logic                              rsp_found_o,
  output logic [rxq_pkg::NODE_W-1:0]        rsp_src_o,
  output logic signed [rxq_pkg::TYPE_W-1:0] rsp_type_o,
  output logic [rxq_pkg::LEN_W-1:0]         rsp_len_o,
  output logic [rxq_pkg::HND_W-1:0]         rsp_hnd_o,
  output logic                              sys_valid_o,
  output logic [rxq_pkg::NODE_W-1:0]        sys_src_o,
  output logic signed [rxq_pkg::TYPE_W-1:0] sys_type_o,
  output logic [rxq_pkg::LEN_W-1:0]         sys_len_o,
  output logic [rxq_pkg::HND_W-1:0]         sys_hnd_o
);
  import rxq_pkg::*;

  // reset: asserted at once, released after two clock edges
  logic rst_meta, rst_n_s;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  hdr_t             ent_w [DEPTH];
  logic [DEPTH-1:0] vld_w, hit_w;
  logic [CNT_W-1:0] count_w;
  logic [IDX_W-1:0] hit_idx;
  logic             hit_any, enq_sys, full_w, ins_en, rm_en;
  hdr_t             enq_hdr, sel_hdr;

  assign enq_hdr = '{src: enq_src_i, typ: enq_type_i, len: enq_len_i, hnd: enq_hnd_i};
  assign enq_sys = (enq_type_i < TYPE_ANY);
  assign full_w  = (count_w == CNT_W'(DEPTH));
  assign ins_en  = enq_valid_i && !enq_sys && !full_w;
  assign rm_en   = req_valid_i && hit_any;
  assign sel_hdr = ent_w[hit_idx];

  rxq_match #(.DEPTH(DEPTH)) u_match (
    .ent_i(ent_w), .vld_i(vld_w), .req_src_i(req_src_i),
    .req_type_i(req_type_i), .hit_o(hit_w)
  );

  rxq_pick #(.N(DEPTH)) u_pick (
    .vec_i(hit_w), .any_o(hit_any), .idx_o(hit_idx)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_n_s), .rm_en_i(rm_en), .rm_idx_i(hit_idx),
    .ins_en_i(ins_en), .ins_ent_i(enq_hdr), .ent_o(ent_w), .vld_o(vld_w),
    .count_o(count_w)
  );

  // response and system-message output registers
  logic rsp_v_q, rsp_f_q, sys_v_q, rsp_f_n;
  hdr_t rsp_q, sys_q, rsp_n;

  always_comb begin
    rsp_f_n = hit_any;
    rsp_n   = hit_any ? sel_hdr : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rsp_v_q <= 1'b0;
      rsp_f_q <= 1'b0;
      sys_v_q <= 1'b0;
    end else begin
      rsp_v_q <= req_valid_i;
      rsp_f_q <= req_valid_i && rsp_f_n;
      sys_v_q <= enq_valid_i && enq_sys;
    end
  end

  always_ff @(posedge clk_i) begin
    if (req_valid_i)            rsp_q <= rsp_n;
    if (enq_valid_i && enq_sys) sys_q <= enq_hdr;
  end

  assign queue_full_o = full_w;
  assign rsp_valid_o  = rsp_v_q;
  assign rsp_found_o  = rsp_f_q;
  assign rsp_src_o    = rsp_v_q ? rsp_q.src : '0;
  assign rsp_type_o   = rsp_v_q ? rsp_q.typ : '0;
  assign rsp_len_o    = rsp_v_q ? rsp_q.len : '0;
  assign rsp_hnd_o    = rsp_v_q ? rsp_q.hnd : '0;
  assign sys_valid_o  = sys_v_q;
  assign sys_src_o    = sys_v_q ? sys_q.src : '0;
  assign sys_type_o   = sys_v_q ? sys_q.typ : '0;
  assign sys_len_o    = sys_v_q ? sys_q.len : '0;
  assign sys_hnd_o    = sys_v_q ? sys_q.hnd : '0;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = 5
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_valid,
  input logic                              enq_valid,
  input logic signed [rxq_pkg::TYPE_W-1:0] req_type,
  input logic                              rsp_valid,
  input logic                              rsp_found,
  input logic signed [rxq_pkg::TYPE_W-1:0] rsp_type,
  input logic                              sys_valid,
  input logic signed [rxq_pkg::TYPE_W-1:0] sys_type,
  input logic [CNT_W-1:0]                  count,
  input logic                              full
);
  import rxq_pkg::*;

  p_rsp_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_type_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_found && ($past(req_type) != TYPE_ANY)
      |-> rsp_type == $past(req_type));

  p_sys_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |-> (sys_type < TYPE_ANY));

  p_no_sys_to_user_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_found |-> !(rsp_type < TYPE_ANY));

  p_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_found && !$past(enq_valid) |-> count == $past(count));

  p_hit_removes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_found && !$past(enq_valid)
      |-> count == CNT_W'($past(count) - 1'b1));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && enq_valid && !req_valid |=> count == CNT_W'(DEPTH));
endmodule

bind rx_tag_queue rxq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_n_s), .req_valid(req_valid_i), .enq_valid(enq_valid_i),
  .req_type(req_type_i), .rsp_valid(rsp_valid_o), .rsp_found(rsp_found_o),
  .rsp_type(rsp_type_o), .sys_valid(sys_valid_o), .sys_type(sys_type_o),
  .count(count_w), .full(queue_full_o)
);

// File: tb/rx_tag_queue_test.sv
module rx_tag_queue_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               enq_valid_i = 1'b0;
  logic [9:0]         enq_src_i = '0;
  logic signed [15:0] enq_type_i = '0;
  logic [16:0]        enq_len_i = '0;
  logic [7:0]         enq_hnd_i = '0;
  logic               req_valid_i = 1'b0;
  logic signed [10:0] req_src_i = '0;
  logic signed [15:0] req_type_i = '0;
  logic               queue_full_o, rsp_valid_o, rsp_found_o, sys_valid_o;
  logic [9:0]         rsp_src_o, sys_src_o;
  logic signed [15:0] rsp_type_o, sys_type_o;
  logic [16:0]        rsp_len_o, sys_len_o;
  logic [7:0]         rsp_hnd_o, sys_hnd_o;

  rx_tag_queue uut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_valid_i), .enq_src_i(enq_src_i), .enq_type_i(enq_type_i),
    .enq_len_i(enq_len_i), .enq_hnd_i(enq_hnd_i), .queue_full_o(queue_full_o),
    .req_valid_i(req_valid_i), .req_src_i(req_src_i), .req_type_i(req_type_i),
    .rsp_valid_o(rsp_valid_o), .rsp_found_o(rsp_found_o), .rsp_src_o(rsp_src_o),
    .rsp_type_o(rsp_type_o), .rsp_len_o(rsp_len_o), .rsp_hnd_o(rsp_hnd_o),
    .sys_valid_o(sys_valid_o), .sys_src_o(sys_src_o), .sys_type_o(sys_type_o),
    .sys_len_o(sys_len_o), .sys_hnd_o(sys_hnd_o)
  );

  typedef struct { int src; int typ; int len; int hnd; } msg_t;
  msg_t mq[$];

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  bit   e_rv, e_rf, e_sv, e_full;
  msg_t e_rsp, e_sys;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(rsp_valid_o == e_rv, tag, "rsp_valid", int'(rsp_valid_o), int'(e_rv));
    chk(sys_valid_o == e_sv, tag, "sys_valid", int'(sys_valid_o), int'(e_sv));
    chk(queue_full_o == e_full, tag, "queue_full", int'(queue_full_o), int'(e_full));
    if (e_rv) begin
      chk(rsp_found_o == e_rf, tag, "rsp_found", int'(rsp_found_o), int'(e_rf));
      chk(int'(rsp_src_o) == e_rsp.src, tag, "rsp_src", int'(rsp_src_o), e_rsp.src);
      chk(int'(rsp_type_o) == e_rsp.typ, tag, "rsp_type", int'(rsp_type_o), e_rsp.typ);
      chk(int'(rsp_len_o) == e_rsp.len, tag, "rsp_len", int'(rsp_len_o), e_rsp.len);
      chk(int'(rsp_hnd_o) == e_rsp.hnd, tag, "rsp_hnd", int'(rsp_hnd_o), e_rsp.hnd);
    end
    if (e_sv) begin
      chk(int'(sys_src_o) == e_sys.src, tag, "sys_src", int'(sys_src_o), e_sys.src);
      chk(int'(sys_type_o) == e_sys.typ, tag, "sys_type", int'(sys_type_o), e_sys.typ);
      chk(int'(sys_len_o) == e_sys.len, tag, "sys_len", int'(sys_len_o), e_sys.len);
      chk(int'(sys_hnd_o) == e_sys.hnd, tag, "sys_hnd", int'(sys_hnd_o), e_sys.hnd);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(bit ev, int es, int et, int el, int eh,
                     bit rv, int rs, int rt, string tag);
    int   start_sz;
    int   hit;
    msg_t m;
    enq_valid_i = ev; enq_src_i = es[9:0]; enq_type_i = et[15:0];
    enq_len_i = el[16:0]; enq_hnd_i = eh[7:0];
    req_valid_i = rv; req_src_i = rs[10:0]; req_type_i = rt[15:0];
    @(posedge clk);
    start_sz = mq.size();
    e_rv = rv; e_rf = 1'b0; e_rsp = '{0, 0, 0, 0};
    if (rv && !(rt < -1)) begin
      hit = -1;
      for (int i = 0; i < mq.size(); i++) begin
        if (hit < 0 && (rs == -1 || rs == mq[i].src) && (rt == -1 || rt == mq[i].typ))
          hit = i;
      end
      if (hit >= 0) begin
        e_rf = 1'b1; e_rsp = mq[hit]; mq.delete(hit);
      end
    end
    e_sv = ev && (et < -1);
    if (e_sv) e_sys = '{es, et, el, eh};
    if (ev && !(et < -1) && start_sz < DEPTH) begin
      m = '{es, et, el, eh};
      mq.push_back(m);
    end
    e_full = (mq.size() == DEPTH);
    @(negedge clk);
    compare(tag);
    enq_valid_i = 1'b0; req_valid_i = 1'b0;
  endtask

  task automatic enq(int s, int t, int l, int h, string tag);
    cyc(1'b1, s, t, l, h, 1'b0, 0, 0, tag);
  endtask

  task automatic req(int s, int t, string tag);
    cyc(1'b0, 0, 0, 0, 0, 1'b1, s, t, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    e_rv = 0; e_sv = 0; e_full = 0; e_rf = 0;
    compare("R1");
    req(-1, -1, "R1");                      // empty store answers not-found

    // R2, R7: same source and type kept oldest first
    enq(5, 7, 100, 1, "R2");
    enq(3, 7, 200, 2, "R2");
    enq(5, 9, 300, 3, "R2");
    enq(5, 7, 65536, 4, "R10");
    req(5, 7, "R2");                        // handle 1
    req(5, 7, "R7");                        // handle 4, len 65536 (R10)
    // R3: source wildcard
    enq(6, 7, 10, 5, "R3");
    req(-1, 7, "R3");                       // handle 2
    // R4: type wildcard, then both wildcards
    req(5, -1, "R4");                       // handle 3
    enq(8, 2, 11, 6, "R4");
    req(-1, -1, "R4");                      // handle 5
    // R6: miss leaves the store alone
    req(9, 3, "R6");
    req(8, 3, "R6");
    req(-1, -1, "R6");                      // handle 6 still present
    // R5: system types go to their own output
    enq(4, -5, 77, 9, "R5");
    enq(4, -32768, 78, 10, "R5");
    req(-1, -1, "R5");                      // nothing stored
    enq(4, -1, 79, 11, "R5");               // -1 as a type is a user header
    req(4, -5, "R5");
    req(-1, -1, "R5");                      // handle 11
    // R7: removal from the middle keeps order
    for (int i = 0; i < 6; i++) enq(i, 1, i, 20 + i, "R7");
    req(3, 1, "R7");
    for (int i = 0; i < 5; i++) req(-1, -1, "R7");
    // R8: fill, refuse, system bypass when full
    for (int i = 0; i < DEPTH; i++) enq(i, 3, i, 40 + i, "R8");
    enq(99, 3, 5, 99, "R8");
    enq(12, -2, 5, 98, "R8");
    // R9: request and enqueue together on a full store
    cyc(1'b1, 100, 3, 1, 97, 1'b1, 5, 3, "R9");
    req(-1, -1, "R9");
    for (int i = 0; i < DEPTH; i++) req(-1, 3, "R9");
    // R9: on an empty store the request does not see the new header
    cyc(1'b1, 1, 1, 1, 90, 1'b1, -1, -1, "R9");
    req(-1, -1, "R9");

    // random mix against the model
    for (int n = 0; n < 1500; n++) begin
      bit ev, rv;
      int et, rs, rt;
      ev = ($urandom_range(0, 9) < 6);
      rv = ($urandom_range(0, 9) < 5);
      et = ($urandom_range(0, 9) == 0) ? -3 : int'($urandom_range(0, 3));
      rs = int'($urandom_range(0, 4)) - 1;
      rt = ($urandom_range(0, 19) == 0) ? -3 : int'($urandom_range(0, 4)) - 1;
      cyc(ev, int'($urandom_range(0, 3)), et, int'($urandom_range(0, 65536)),
          int'($urandom_range(0, 255)), rv, rs, rt, "R2");
    end
    finish_run();
  end
endmodule